// File: doc/BRIEF.md
# Burst-of-two DDR common-I/O SRAM core

This block is a synthesizable model of a small synchronous static RAM with one shared data bus, split here into an input port, an output port and an output enable. Commands are taken on the rising edge of the primary clock `k_i`. A complementary clock `kn_i`, 180 degrees out of phase, carries the second half of every data transfer. Every access moves a fixed burst of two words. Beat 0 uses the external base address with a zero appended as the low bit, and beat 1 uses the same base with a one appended.

Write data follows its command by one cycle. It is held in a late-write buffer that is only retired into the array when the next write's data arrives. Any read that touches the buffered burst sees the new bytes merged lane by lane, so the memory stays fully coherent. Read data leaves 2.0 cycles after the command, on a K rising edge and then the next K# edge. An output-enable pulse and a pair of echo clocks accompany it.

Top module: `ddr_cio_sram`

## Requirements
- R1: While `rst_ni` is low, `q_o`, `oe_o`, `cq_o` and `cqn_o` are all low.
- R2: A read captured on K edge m shows beat 0 (word `{addr,0}`) on `q_o` after K edge m+2, and beat 1 (word `{addr,1}`) after the K# edge that follows.
- R3: `oe_o` is high for exactly the two beat half-periods of each read and low otherwise. Reads on consecutive edges keep it high without a gap. `q_o` is zero whenever `oe_o` is low.
- R4: After reset, `cq_o` is high in every half-period that follows a K edge and `cqn_o` is high in every half-period that follows a K# edge. The two are never high together.
- R5: For a write captured on K edge n, beat 0 data and strobes are sampled on K edge n+1, and beat 1 data and strobes on the K# edge after that.
- R6: Strobe bit j of `bw_i` (active high) enables bits 9j+8..9j of the beat it accompanies. A lane whose strobe is low keeps its stored byte.
- R7: A read of the burst held in the late-write buffer returns the buffered bytes merged over the stored word.
- R8: A read captured before a write to the same address returns the old data, even though the write data enters during the read's output window.
- R9: When `rd_i` and `wr_i` are both high on one K edge, the read is performed and the write is dropped. The following data beats change nothing.
- R10: A buffered burst is retired to the array when the next write's beat 0 is captured. Its data remains readable after later writes to other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_i | input | 1 | Primary clock K |
| kn_i | input | 1 | Complementary clock K# |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Burst base address |
| rd_i | input | 1 | Read command |
| wr_i | input | 1 | Write command |
| bw_i | input | DATA_W/9 | Per-lane write strobes, active high |
| d_i | input | DATA_W | Write data, both beats |
| q_o | output | DATA_W | Read data, both beats |
| oe_o | output | 1 | Drive enable for the shared bus |
| cq_o | output | 1 | Echo clock, beat-0 phase |
| cqn_o | output | 1 | Echo clock, beat-1 phase |

## Verification
A read's beat 0 is due one nanosecond after the second K rising edge following the capture edge, and beat 1 one nanosecond after the K# edge that comes next. The bench samples exactly there and again one cycle later to see the enable drop. Write beats are driven a nanosecond after the edge that precedes their capture edge, so that K edge n+1 and the following K# edge see stable values. The coherency cases work by placing a read command directly after a write, or directly before one, and checking which data comes back at the read's fixed output slot.

// File: rtl/ddr_cio_pkg.sv
package ddr_cio_pkg;
  localparam int LANE_W = 9;
  typedef enum logic [1:0] {CMD_NOP, CMD_RD, CMD_WR} cmd_e;
endpackage

// File: rtl/ddr_cio_cmd.sv
module ddr_cio_cmd import ddr_cio_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              k_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              rd_v2_o,
  output logic [ADDR_W-1:0] rd_base2_o,
  output logic              wr_v1_o,
  output logic [ADDR_W-1:0] wr_base1_o
);
  cmd_e              cmd;
  logic              rd_v1;
  logic [ADDR_W-1:0] rd_base1;

  // read wins a same-edge collision
  always_comb begin
    if (rd_i)      cmd = CMD_RD;
    else if (wr_i) cmd = CMD_WR;
    else           cmd = CMD_NOP;
  end

  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v1      <= 1'b0;
      rd_v2_o    <= 1'b0;
      wr_v1_o    <= 1'b0;
      rd_base1   <= '0;
      rd_base2_o <= '0;
      wr_base1_o <= '0;
    end else begin
      rd_v1      <= (cmd == CMD_RD);
      rd_v2_o    <= rd_v1;
      wr_v1_o    <= (cmd == CMD_WR);
      rd_base2_o <= rd_base1;
      if (cmd == CMD_RD) rd_base1   <= addr_i;
      if (cmd == CMD_WR) wr_base1_o <= addr_i;
    end
  end
endmodule

// File: rtl/ddr_cio_wbuf.sv
module ddr_cio_wbuf import ddr_cio_pkg::*; #(
  parameter  int ADDR_W = 4,
  parameter  int DATA_W = 18,
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              k_i,
  input  logic              kn_i,
  input  logic              rst_ni,
  input  logic              wr_v1_i,
  input  logic [ADDR_W-1:0] wr_base1_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [LANES-1:0]  bw_i,
  output logic              buf_v_o,
  output logic [ADDR_W-1:0] buf_base_o,
  output logic [DATA_W-1:0] buf_d0_o,
  output logic [DATA_W-1:0] buf_d1_o,
  output logic [LANES-1:0]  buf_be0_o,
  output logic [LANES-1:0]  buf_be1_o,
  output logic              commit_o
);
  logic b1_pend;

  // retire the held burst as the next one arrives
  assign commit_o = wr_v1_i && buf_v_o;

  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_v_o    <= 1'b0;
      buf_base_o <= '0;
      buf_d0_o   <= '0;
      buf_be0_o  <= '0;
      b1_pend    <= 1'b0;
    end else begin
      b1_pend <= wr_v1_i;
      if (wr_v1_i) begin
        buf_v_o    <= 1'b1;
        buf_base_o <= wr_base1_i;
        buf_d0_o   <= d_i;
        buf_be0_o  <= bw_i;
      end
    end
  end

  always_ff @(posedge kn_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_d1_o  <= '0;
      buf_be1_o <= '0;
    end else if (b1_pend) begin
      buf_d1_o  <= d_i;
      buf_be1_o <= bw_i;
    end
  end
endmodule

// File: rtl/ddr_cio_array.sv
module ddr_cio_array import ddr_cio_pkg::*; #(
  parameter  int ADDR_W = 4,
  parameter  int DATA_W = 18,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int DEPTH  = 2 ** (ADDR_W + 1)
) (
  input  logic              k_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wbase_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  input  logic [LANES-1:0]  be0_i,
  input  logic [LANES-1:0]  be1_i,
  input  logic [ADDR_W-1:0] rbase_i,
  output logic [DATA_W-1:0] rw0_o,
  output logic [DATA_W-1:0] rw1_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge k_i) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (be0_i[l]) mem[{wbase_i, 1'b0}][l*LANE_W +: LANE_W] <= d0_i[l*LANE_W +: LANE_W];
        if (be1_i[l]) mem[{wbase_i, 1'b1}][l*LANE_W +: LANE_W] <= d1_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rw0_o = mem[{rbase_i, 1'b0}];
  assign rw1_o = mem[{rbase_i, 1'b1}];
endmodule

// File: rtl/ddr_cio_rdout.sv
module ddr_cio_rdout import ddr_cio_pkg::*; #(
  parameter  int ADDR_W = 4,
  parameter  int DATA_W = 18,
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              k_i,
  input  logic              kn_i,
  input  logic              rst_ni,
  input  logic              rd_v2_i,
  input  logic [ADDR_W-1:0] rd_base2_i,
  input  logic [DATA_W-1:0] rw0_i,
  input  logic [DATA_W-1:0] rw1_i,
  input  logic              buf_v_i,
  input  logic [ADDR_W-1:0] buf_base_i,
  input  logic [DATA_W-1:0] buf_d0_i,
  input  logic [DATA_W-1:0] buf_d1_i,
  input  logic [LANES-1:0]  buf_be0_i,
  input  logic [LANES-1:0]  buf_be1_i,
  output logic [DATA_W-1:0] q_o,
  output logic              oe_o,
  output logic              cq_o,
  output logic              cqn_o
);
  logic              hit;
  logic [DATA_W-1:0] m0, m1;
  logic [DATA_W-1:0] q0_r, q1_r, qn_r;
  logic              oe_k, oe_n, k_ph, kn_ph, run, half_b;

  assign hit = buf_v_i && (buf_base_i == rd_base2_i);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign m0[l*LANE_W +: LANE_W] = (hit && buf_be0_i[l]) ? buf_d0_i[l*LANE_W +: LANE_W]
                                                          : rw0_i[l*LANE_W +: LANE_W];
    assign m1[l*LANE_W +: LANE_W] = (hit && buf_be1_i[l]) ? buf_d1_i[l*LANE_W +: LANE_W]
                                                          : rw1_i[l*LANE_W +: LANE_W];
  end

  // both beats latched on K so a later write cannot disturb beat 1
  always_ff @(posedge k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q0_r <= '0;
      q1_r <= '0;
      oe_k <= 1'b0;
      k_ph <= 1'b0;
      run  <= 1'b0;
    end else begin
      q0_r <= m0;
      q1_r <= m1;
      oe_k <= rd_v2_i;
      k_ph <= ~k_ph;
      run  <= 1'b1;
    end
  end

  always_ff @(posedge kn_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qn_r  <= '0;
      oe_n  <= 1'b0;
      kn_ph <= 1'b0;
    end else begin
      qn_r  <= q1_r;
      oe_n  <= oe_k;
      kn_ph <= k_ph;
    end
  end

  // phases equal once K# has followed the last K edge
  assign half_b = (k_ph == kn_ph);

  always_comb begin
    if (half_b) begin
      oe_o = oe_n;
      q_o  = oe_n ? qn_r : '0;
    end else begin
      oe_o = oe_k;
      q_o  = oe_k ? q0_r : '0;
    end
  end

  assign cq_o  = run && !half_b;
  assign cqn_o = run && half_b;
endmodule

// File: rtl/ddr_cio_sram.sv
module ddr_cio_sram import ddr_cio_pkg::*; #(
  parameter  int ADDR_W = 4,
  parameter  int DATA_W = 18,
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              k_i,
  input  logic              kn_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  bw_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              oe_o,
  output logic              cq_o,
  output logic              cqn_o
);
  logic              rd_v2, wr_v1, buf_v, commit;
  logic [ADDR_W-1:0] rd_base2, wr_base1, buf_base;
  logic [DATA_W-1:0] buf_d0, buf_d1, rw0, rw1;
  logic [LANES-1:0]  buf_be0, buf_be1;

  ddr_cio_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .k_i, .rst_ni, .addr_i, .rd_i, .wr_i,
    .rd_v2_o(rd_v2), .rd_base2_o(rd_base2),
    .wr_v1_o(wr_v1), .wr_base1_o(wr_base1)
  );

  ddr_cio_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .k_i, .kn_i, .rst_ni,
    .wr_v1_i(wr_v1), .wr_base1_i(wr_base1), .d_i, .bw_i,
    .buf_v_o(buf_v), .buf_base_o(buf_base),
    .buf_d0_o(buf_d0), .buf_d1_o(buf_d1),
    .buf_be0_o(buf_be0), .buf_be1_o(buf_be1),
    .commit_o(commit)
  );

  ddr_cio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .k_i, .we_i(commit), .wbase_i(buf_base),
    .d0_i(buf_d0), .d1_i(buf_d1), .be0_i(buf_be0), .be1_i(buf_be1),
    .rbase_i(rd_base2), .rw0_o(rw0), .rw1_o(rw1)
  );

  ddr_cio_rdout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdout (
    .k_i, .kn_i, .rst_ni,
    .rd_v2_i(rd_v2), .rd_base2_i(rd_base2), .rw0_i(rw0), .rw1_i(rw1),
    .buf_v_i(buf_v), .buf_base_i(buf_base),
    .buf_d0_i(buf_d0), .buf_d1_i(buf_d1),
    .buf_be0_i(buf_be0), .buf_be1_i(buf_be1),
    .q_o, .oe_o, .cq_o, .cqn_o
  );
endmodule

// File: rtl/ddr_cio_sram_chk.sv
module ddr_cio_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              k_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [DATA_W-1:0] q_o,
  input logic              oe_o,
  input logic              cq_o,
  input logic              cqn_o
);
  always_comb begin
    if (!rst_ni) assert_quiet_in_reset_R1: assert (!oe_o && !cq_o && !cqn_o && q_o == '0);
    assert_echo_exclusive_R4: assert (!(cq_o && cqn_o));
    if (!oe_o) assert_q_idle_R3: assert (q_o == '0);
  end

  assert_read_latency_R2: assert property (@(posedge k_i) disable iff (!rst_ni)
    rd_i |-> ##3 oe_o);

  assert_no_stray_enable_R3: assert property (@(posedge k_i) disable iff (!rst_ni)
    !rd_i |-> ##3 !oe_o);

  assert_echo_phase_R4: assert property (@(posedge k_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (cqn_o && !cq_o));
endmodule

bind ddr_cio_sram ddr_cio_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .k_i(k_i), .rst_ni(rst_ni), .rd_i(rd_i), .q_o(q_o),
  .oe_o(oe_o), .cq_o(cq_o), .cqn_o(cqn_o)
);

// File: tb/ddr_cio_sram_bench.sv
module ddr_cio_sram_bench;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int LN = DW / 9;

  logic          k_i = 1'b0;
  logic          kn_i;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [LN-1:0] bw_i = '0;
  logic [DW-1:0] d_i = '0;
  logic [DW-1:0] q_o;
  logic          oe_o, cq_o, cqn_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] mdl [2**(AW+1)];

  always #2 k_i = ~k_i;
  assign kn_i = ~k_i;

  ddr_cio_sram #(.ADDR_W(AW), .DATA_W(DW)) u_ddr_cio_sram (
    .k_i, .kn_i, .rst_ni, .addr_i, .rd_i, .wr_i, .bw_i, .d_i,
    .q_o, .oe_o, .cq_o, .cqn_o
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] lmerge(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [LN-1:0] be);
    logic [DW-1:0] r = o;
    for (int l = 0; l < LN; l++) if (be[l]) r[l*9 +: 9] = n[l*9 +: 9];
    return r;
  endfunction

  task automatic kstep(); @(posedge k_i); #1; endtask
  task automatic nstep(); @(negedge k_i); #1; endtask

  // R5 R6: beat 0 sampled one edge after the command, beat 1 on the next K#
  task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [LN-1:0] b0,
                       input logic [DW-1:0] d1, input logic [LN-1:0] b1);
    wr_i = 1'b1; addr_i = a;
    kstep();
    wr_i = 1'b0; d_i = d0; bw_i = b0;
    kstep();
    d_i = d1; bw_i = b1;
    nstep();
    bw_i = '0; d_i = 18'h2aaaa;
    kstep();
    mdl[{a, 1'b0}] = lmerge(mdl[{a, 1'b0}], d0, b0);
    mdl[{a, 1'b1}] = lmerge(mdl[{a, 1'b1}], d1, b1);
  endtask

  task automatic rd_op(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] e0, e1;
    e0 = mdl[{a, 1'b0}]; e1 = mdl[{a, 1'b1}];
    rd_i = 1'b1; addr_i = a;
    kstep();
    rd_i = 1'b0;
    kstep();
    chk(!oe_o, {tag, " R3 oe early"}, DW'(oe_o), '0);
    kstep();
    chk(q_o === e0 && oe_o && cq_o, {tag, " R2 beat0"}, q_o, e0);
    nstep();
    chk(q_o === e1 && oe_o && cqn_o, {tag, " R2 beat1"}, q_o, e1);
    kstep();
    chk(!oe_o && q_o == '0, {tag, " R3 oe end"}, q_o, '0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge k_i);
    #1;
    chk(!oe_o && !cq_o && !cqn_o && q_o == '0, "R1 reset quiet", {q_o[DW-1:3], oe_o, cq_o, cqn_o}, '0);
    rst_ni = 1'b1;
    kstep();
    chk(cq_o && !cqn_o, "R4 cq after K", DW'({cq_o, cqn_o}), DW'(2'b10));
    nstep();
    chk(!cq_o && cqn_o, "R4 cqn after K#", DW'({cq_o, cqn_o}), DW'(2'b01));
    kstep();
  endtask

  task automatic t_basic();
    for (int i = 0; i < 4; i++)
      wr_op(AW'(i), DW'(18'h01010 + i * 18'h01111), '1, DW'(18'h3f0f0 - i * 18'h00707), '1);
    rd_op(4'd1, "R10 committed");
    rd_op(4'd3, "R7 buffered");
    rd_op(4'd0, "R10 oldest");
  endtask

  task automatic t_lanes();
    wr_op(4'd5, 18'h11111, '1, 18'h22222, '1);
    wr_op(4'd5, 18'h3fe00, 2'b10, 18'h001ff, 2'b01);
    rd_op(4'd5, "R6 lane merge buffered");
    wr_op(4'd6, 18'h0abcd, '1, 18'h1dcba, '1);
    rd_op(4'd5, "R6 lane merge committed");
  endtask

  task automatic t_priority();
    logic [DW-1:0] e0, e1;
    e0 = mdl[{4'd2, 1'b0}]; e1 = mdl[{4'd2, 1'b1}];
    rd_i = 1'b1; wr_i = 1'b1; addr_i = 4'd2;
    kstep();
    rd_i = 1'b0; wr_i = 1'b0; d_i = 18'h15555; bw_i = '1;
    kstep();
    d_i = 18'h0cccc;
    nstep();
    bw_i = '0;
    kstep();
    chk(q_o === e0 && oe_o, "R9 read wins beat0", q_o, e0);
    nstep();
    chk(q_o === e1, "R9 read wins beat1", q_o, e1);
    kstep();
    rd_op(4'd2, "R9 write dropped");
  endtask

  task automatic t_order();
    logic [DW-1:0] o0, o1;
    o0 = mdl[{4'd1, 1'b0}]; o1 = mdl[{4'd1, 1'b1}];
    rd_i = 1'b1; addr_i = 4'd1;
    kstep();
    rd_i = 1'b0; wr_i = 1'b1;
    kstep();
    wr_i = 1'b0; d_i = 18'h3c3c3; bw_i = '1;
    kstep();
    chk(q_o === o0, "R8 old beat0", q_o, o0);
    d_i = 18'h1b1b1;
    nstep();
    chk(q_o === o1, "R8 old beat1", q_o, o1);
    bw_i = '0;
    kstep();
    mdl[{4'd1, 1'b0}] = 18'h3c3c3;
    mdl[{4'd1, 1'b1}] = 18'h1b1b1;
    rd_op(4'd1, "R7 new after read");
  endtask

  task automatic t_b2b();
    rd_i = 1'b1; addr_i = 4'd0;
    kstep();
    addr_i = 4'd6;
    kstep();
    rd_i = 1'b0;
    kstep();
    chk(q_o === mdl[0], "R2 b2b first beat0", q_o, mdl[0]);
    nstep();
    chk(q_o === mdl[1], "R2 b2b first beat1", q_o, mdl[1]);
    kstep();
    chk(q_o === mdl[12] && oe_o, "R3 b2b no gap", q_o, mdl[12]);
    nstep();
    chk(q_o === mdl[13] && oe_o, "R3 b2b second beat1", q_o, mdl[13]);
    kstep();
    chk(!oe_o, "R3 b2b end", DW'(oe_o), '0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lanes();
    t_priority();
    t_order();
    t_b2b();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule